// File: doc/BRIEF.md
# Exclusive Access Monitor

This block watches the stream of memory transactions seen by a shared target and decides, for each exclusive write, whether the lock attempt that the write closes has succeeded. Each observed event carries the requesting master's index, a byte address, a direction flag and an exclusive flag. An exclusive read opens a reservation for its master. The matching exclusive write later passes only if that reservation is still intact.

One reservation register exists per master. A passing exclusive write is answered with the EXOKAY code and may commit to memory. A failing one is answered with the plain OKAY code and its commit-enable is held low, so the target must drop the data. Plain writes always commit, and they break other masters' reservations on the same granule. Addresses are compared at an aligned granule whose size is a parameter. Every write gets a response one clock after the event. Reads get none.

Top module: `excl_monitor`

## Requirements
- R1: An exclusive read (`ev_excl`=1, `ev_write`=0) stores the granule of `ev_addr` in the reservation of master `ev_master` and marks it valid. No response is produced for any read.
- R2: An exclusive write whose master holds a valid reservation for the same granule produces, one clock after the event, `rsp_valid`=1, `rsp_code`=2'b01 (EXOKAY) and `commit_en`=1.
- R3: An exclusive write whose master holds no valid reservation, or holds one for a different granule, produces `rsp_code`=2'b00 (OKAY) and `commit_en`=0 one clock after the event.
- R4: An exclusive write invalidates its own master's reservation whether it passes or fails. A repeated exclusive write with no new exclusive read therefore fails.
- R5: A non-exclusive write from another master to a granule reserved by master m invalidates m's reservation.
- R6: A passing exclusive write invalidates every other master's reservation for the same granule. A failing exclusive write leaves other masters' reservations unchanged.
- R7: A non-exclusive write produces `rsp_code`=2'b00 with `commit_en`=1 one clock after the event. `rsp_valid` is 0 in the clock after any cycle without a write event, including when `ev_valid`=0.
- R8: Two addresses match when they differ only in the low log2(`GRANULE_BYTES`) bits (default 4 bytes). Addresses in different granules never match.
- R9: A new exclusive read from a master replaces that master's earlier reservation.
- R10: Plain reads from any master, and plain writes from the reservation's own master, leave the reservation unchanged.
- R11: While reset is active and after it is released, `rsp_valid`, `rsp_code` and `commit_en` are 0 and all reservations are invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ev_valid | input | 1 | An observed transaction is present this cycle |
| ev_master | input | ID_W | Index of the issuing master |
| ev_addr | input | ADDR_W | Byte address of the transaction |
| ev_write | input | 1 | 1 = write, 0 = read |
| ev_excl | input | 1 | 1 = exclusive access |
| rsp_valid | output | 1 | Decision for a write event, one clock after it |
| rsp_code | output | 2 | 2'b01 EXOKAY, 2'b00 OKAY |
| commit_en | output | 1 | The write may update memory |

## Verification
The checker checks these rules on every cycle: each write event gets exactly one response in the next clock, and reads and idle cycles get none. A plain write is always answered with OKAY and allowed to commit. The commit enable follows the EXOKAY code for exclusive writes. Two back-to-back exclusive writes from one master cannot both pass. How reservations survive or fall across sequences depends on what other masters do in between: plain writes from others, plain writes and reads from the owner, failed and passing exclusive writes, replacement by a newer exclusive read, and addresses inside and outside a granule. Only the bench's scripted scenarios can show this, by closing each sequence with an exclusive write whose answer exposes the reservation state.

// File: rtl/excl_pkg.sv
package excl_pkg;

  typedef enum logic [1:0] {
    RSP_OKAY   = 2'b00,
    RSP_EXOKAY = 2'b01
  } rsp_code_e;

endpackage

// File: rtl/excl_rst_sync.sv
module excl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/excl_slot.sv
module excl_slot #(
  parameter int ADDR_W = 32,
  parameter int GRAN_LSB = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic              clr_en,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [ADDR_W-1:0] cmp_addr,
  output logic              hit
);

  localparam logic [ADDR_W-1:0] GRAN_MASK = {ADDR_W{1'b1}} << GRAN_LSB;

  logic              valid_q, valid_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              addr_en;

  always_comb begin
    valid_d = valid_q;
    addr_en = 1'b0;
    addr_d  = addr_q;
    if (set_en) begin
      valid_d = 1'b1;
      addr_en = 1'b1;
      addr_d  = addr_in & GRAN_MASK;
    end else if (clr_en) begin
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_en) begin
      addr_q <= addr_d;
    end
  end

  assign hit = valid_q && (addr_q == (cmp_addr & GRAN_MASK));

endmodule

// File: rtl/excl_rsp_reg.sv
module excl_rsp_reg
  import excl_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load,
  input  rsp_code_e code_d,
  input  logic      commit_d,
  output logic      rsp_valid,
  output logic [1:0] rsp_code,
  output logic      commit_en
);

  logic      vld_q;
  rsp_code_e code_q;
  logic      commit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= load;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q   <= RSP_OKAY;
      commit_q <= 1'b0;
    end else if (load) begin
      code_q   <= code_d;
      commit_q <= commit_d;
    end else begin
      code_q   <= RSP_OKAY;
      commit_q <= 1'b0;
    end
  end

  assign rsp_valid = vld_q;
  assign rsp_code  = code_q;
  assign commit_en = commit_q;

endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
  import excl_pkg::*;
#(
  parameter int NUM_MASTERS   = 4,
  parameter int ADDR_W        = 32,
  parameter int GRANULE_BYTES = 4,
  localparam int ID_W = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  input  logic [ID_W-1:0]   ev_master,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic              ev_write,
  input  logic              ev_excl,
  output logic              rsp_valid,
  output logic [1:0]        rsp_code,
  output logic              commit_en
);

  localparam int GRAN_LSB = (GRANULE_BYTES > 1) ? $clog2(GRANULE_BYTES) : 0;

  logic                   rst_sync_n;
  logic [NUM_MASTERS-1:0] own_vec;
  logic [NUM_MASTERS-1:0] hit_vec;
  logic [NUM_MASTERS-1:0] set_vec;
  logic [NUM_MASTERS-1:0] clr_vec;
  logic                   wr_ev, xrd_ev, xwr_ev;
  logic                   pass;
  rsp_code_e              code_d;
  logic                   commit_d;

  excl_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_sync_n)
  );

  assign wr_ev  = ev_valid && ev_write;
  assign xrd_ev = ev_valid && !ev_write && ev_excl;
  assign xwr_ev = wr_ev && ev_excl;

  // exclusive write passes only on the issuing master's own live reservation
  assign pass = xwr_ev && |(own_vec & hit_vec);

  generate
    for (genvar i = 0; i < NUM_MASTERS; i++) begin : g_slot
      assign own_vec[i] = (ev_master == ID_W'(i));

      // own reservation: opened by exclusive read, closed by own exclusive write
      // other reservations: broken by plain writes or passing exclusive writes
      assign set_vec[i] = xrd_ev && own_vec[i];
      assign clr_vec[i] = (xwr_ev && own_vec[i]) ||
                          (wr_ev && !own_vec[i] && hit_vec[i] && (!ev_excl || pass));

      excl_slot #(
        .ADDR_W   (ADDR_W),
        .GRAN_LSB (GRAN_LSB)
      ) u_slot (
        .clk      (clk),
        .rst_n    (rst_sync_n),
        .set_en   (set_vec[i]),
        .clr_en   (clr_vec[i]),
        .addr_in  (ev_addr),
        .cmp_addr (ev_addr),
        .hit      (hit_vec[i])
      );
    end
  endgenerate

  always_comb begin
    code_d   = pass ? RSP_EXOKAY : RSP_OKAY;
    commit_d = !ev_excl || pass;
  end

  excl_rsp_reg u_rsp (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .load      (wr_ev),
    .code_d    (code_d),
    .commit_d  (commit_d),
    .rsp_valid (rsp_valid),
    .rsp_code  (rsp_code),
    .commit_en (commit_en)
  );

endmodule

// File: rtl/excl_monitor_chk.sv
module excl_monitor_chk #(
  parameter int ID_W   = 2,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ev_valid,
  input logic [ID_W-1:0]   ev_master,
  input logic [ADDR_W-1:0] ev_addr,
  input logic              ev_write,
  input logic              ev_excl,
  input logic              rsp_valid,
  input logic [1:0]        rsp_code,
  input logic              commit_en
);

  // R7: every write is answered in the next clock
  p_write_answered_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_write) |=> rsp_valid);

  // R1, R7: reads and idle cycles get no response
  p_no_rsp_for_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_valid && ev_write) |=> !rsp_valid);

  // R7: plain writes are OKAY and always commit
  p_plain_write_okay_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_write && !ev_excl) |=> (rsp_code == 2'b00 && commit_en));

  // R2, R3: exclusive write commits exactly when EXOKAY
  p_commit_tracks_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_write && ev_excl) |=> (commit_en == (rsp_code == 2'b01)));

  // R2: only the two defined codes ever appear
  p_code_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_code == 2'b00 || rsp_code == 2'b01));

  // R4: back-to-back exclusive writes from one master: the second fails
  p_no_double_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_write && ev_excl) ##1
    (ev_valid && ev_write && ev_excl && ev_master == $past(ev_master))
    |=> (rsp_code == 2'b00 && !commit_en));

  wire unused_addr = ^ev_addr;

endmodule

bind excl_monitor excl_monitor_chk #(
  .ID_W   (ID_W),
  .ADDR_W (ADDR_W)
) i_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .ev_valid  (ev_valid),
  .ev_master (ev_master),
  .ev_addr   (ev_addr),
  .ev_write  (ev_write),
  .ev_excl   (ev_excl),
  .rsp_valid (rsp_valid),
  .rsp_code  (rsp_code),
  .commit_en (commit_en)
);

// File: tb/test_excl_monitor.sv
module test_excl_monitor;

  localparam int CLK_PERIOD = 10;
  localparam int NM = 4;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ev_valid = 1'b0;
  logic [1:0]    ev_master = '0;
  logic [AW-1:0] ev_addr = '0;
  logic          ev_write = 1'b0;
  logic          ev_excl = 1'b0;
  logic          rsp_valid;
  logic [1:0]    rsp_code;
  logic          commit_en;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [2:0] q_exp[$];
  string      q_tag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  excl_monitor #(.NUM_MASTERS(NM), .ADDR_W(AW), .GRANULE_BYTES(4)) i_excl_monitor (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_valid  (ev_valid),
    .ev_master (ev_master),
    .ev_addr   (ev_addr),
    .ev_write  (ev_write),
    .ev_excl   (ev_excl),
    .rsp_valid (rsp_valid),
    .rsp_code  (rsp_code),
    .commit_en (commit_en)
  );

  // monitor: compares each response against the scoreboard head
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      n_tests++;
      if (q_exp.size() == 0) begin
        n_fail++;
        $display("FAIL unexpected response (R1/R7): got code=%b commit=%b, expected none",
                 rsp_code, commit_en);
      end else begin
        logic [2:0] e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        if ({1'b1, rsp_code, commit_en} != {1'b1, e}) begin
          n_fail++;
          $display("FAIL %s: got code=%b commit=%b, expected code=%b commit=%b",
                   t, rsp_code, commit_en, e[2:1], e[0]);
        end
      end
    end
  end

  task automatic ev(input int m, input logic [AW-1:0] a, input bit w, input bit x,
                    input bit exp_pass, input string tag);
    ev_valid  = 1'b1;
    ev_master = 2'(m);
    ev_addr   = a;
    ev_write  = w;
    ev_excl   = x;
    if (w) begin
      q_exp.push_back(x ? (exp_pass ? 3'b011 : 3'b000) : 3'b001);
      q_tag.push_back(tag);
    end
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic rd_x(input int m, input logic [AW-1:0] a);
    ev(m, a, 1'b0, 1'b1, 1'b0, "R1");
  endtask

  task automatic wr_x(input int m, input logic [AW-1:0] a, input bit p, input string tag);
    ev(m, a, 1'b1, 1'b1, p, tag);
  endtask

  task automatic wr_p(input int m, input logic [AW-1:0] a, input string tag);
    ev(m, a, 1'b1, 1'b0, 1'b0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired: got hang, expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: outputs quiet during reset
    n_tests++;
    if ({rsp_valid, rsp_code, commit_en} != 4'b0) begin
      n_fail++;
      $display("FAIL R11: got %b, expected 0000", {rsp_valid, rsp_code, commit_en});
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    n_tests++;
    if ({rsp_valid, rsp_code, commit_en} != 4'b0) begin
      n_fail++;
      $display("FAIL R11: got %b after release, expected 0000", {rsp_valid, rsp_code, commit_en});
    end
    // R11: no reservation after reset
    wr_x(3, 32'h0, 1'b0, "R11");

    // R1, R2: basic pair passes
    rd_x(0, 32'h100);
    wr_x(0, 32'h100, 1'b1, "R2");
    // R4: repeat without new read fails
    wr_x(0, 32'h100, 1'b0, "R4");
    // R3: no reservation
    wr_x(1, 32'h200, 1'b0, "R3");
    // R3: reservation on different granule
    rd_x(1, 32'h200);
    wr_x(1, 32'h210, 1'b0, "R3");
    // R5, R7, R8: plain write by another master in the same granule
    rd_x(1, 32'h200);
    wr_p(2, 32'h202, "R7");
    wr_x(1, 32'h200, 1'b0, "R5");
    // R6: passing exclusive write breaks the other master
    rd_x(2, 32'h300);
    rd_x(3, 32'h300);
    wr_x(2, 32'h300, 1'b1, "R6");
    wr_x(3, 32'h300, 1'b0, "R6");
    // R6: failing exclusive write does not break others; R8 low bits ignored
    rd_x(0, 32'h400);
    rd_x(1, 32'h400);
    wr_x(1, 32'h500, 1'b0, "R6");
    wr_x(0, 32'h403, 1'b1, "R8");
    // R9: newer read replaces the older reservation
    rd_x(0, 32'h600);
    rd_x(0, 32'h700);
    wr_x(0, 32'h600, 1'b0, "R9");
    rd_x(0, 32'h600);
    rd_x(0, 32'h700);
    wr_x(0, 32'h700, 1'b1, "R9");
    // R10: owner's plain write and everyone's plain reads keep the reservation
    rd_x(1, 32'h800);
    wr_p(1, 32'h800, "R10");
    ev(1, 32'h800, 1'b0, 1'b0, 1'b0, "R10");
    ev(2, 32'h800, 1'b0, 1'b0, 1'b0, "R10");
    wr_x(1, 32'h800, 1'b1, "R10");
    // R8: neighbouring granule write does not disturb
    rd_x(2, 32'h900);
    wr_p(3, 32'h904, "R8");
    wr_x(2, 32'h900, 1'b1, "R8");
    // R7: idle cycle with write/excl set but ev_valid low gives no response
    rd_x(3, 32'hA00);
    ev_master = 2'd0; ev_addr = 32'hA00; ev_write = 1'b1; ev_excl = 1'b0;
    @(negedge clk);
    @(negedge clk);
    wr_x(3, 32'hA00, 1'b1, "R7");
    repeat (3) @(negedge clk);
    // R7: every write was answered
    n_tests++;
    if (q_exp.size() != 0) begin
      n_fail++;
      $display("FAIL R7: got %0d unanswered writes, expected 0", q_exp.size());
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule